// File: doc/BRIEF.md
# Two-Dice Game Referee

This block referees a two-dice betting game. It takes two die values of 3 bits each, in the range 1 to 6, and a roll strobe from the player. On the rising edge of the strobe it adds the two dice and judges the total. The first roll of a game is judged against fixed winning and losing totals. If the first roll neither wins nor loses, its total is saved as the point. Every later roll is then judged against the saved point and against seven.

The result is held on sticky win and lose outputs. A status output shows that a point has been set and another roll is needed. The saved point is also visible on an output. A synchronous reset, or a synchronous new-game request, starts a fresh game. Die generation and display decoding happen outside the block.

Top module: `dice_referee`

## Requirements
- R1: The decision for a roll depends only on the sum of the two dice. On the first roll of a game, a sum of 7 or 11 sets `win_o` in the cycle after the evaluating clock edge.
- R2: On the first roll of a game, a sum of 2, 3 or 12 sets `lose_o` in the cycle after the evaluating clock edge.
- R3: On the first roll, any other sum (4, 5, 6, 8, 9 or 10) loads that sum into `point_o` and sets `again_o`. The point register loads at no other time.
- R4: On a later roll, a sum equal to the saved point sets `win_o` and clears `again_o`.
- R5: On a later roll, a sum of 7 sets `lose_o` and clears `again_o`.
- R6: On a later roll, any other sum leaves `again_o` set and leaves `point_o` unchanged.
- R7: A roll is evaluated only on a clock edge where `roll_i` is 1 and was 0 at the previous edge. Holding `roll_i` high gives only one evaluation. `roll_i` is seen as 0 before the first edge after reset.
- R8: Once `win_o` or `lose_o` is set, it stays set, and roll strobes have no effect, until reset or new-game.
- R9: When `rst` or `new_game_i` is high at a clock edge, all of the following are cleared, even if a roll edge arrives in the same cycle: `win_o`, `lose_o`, `again_o` and `point_o`. The next roll is then a first roll.
- R10: At most one of `win_o`, `lose_o` and `again_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_game_i | input | 1 | Synchronous request to start a fresh game |
| roll_i | input | 1 | Roll strobe; its rising edge evaluates the dice |
| die_a_i | input | 3 | First die value, 1 to 6 |
| die_b_i | input | 3 | Second die value, 1 to 6 |
| win_o | output | 1 | Game won (sticky) |
| lose_o | output | 1 | Game lost (sticky) |
| again_o | output | 1 | A point is set and another roll is needed |
| point_o | output | 4 | Saved point, 0 when no point is set |

## Verification
The bench plays every first-roll sum from 2 to 12. A design that swaps the rule sets would, for example, lose on a first 7 or win on a first 12. Point games are played with a 7 on the second roll, with the point matched, and with non-deciding sums in between. A design that reloads the point on later rolls, or that tests the point on the first roll, would show a changed `point_o` or an early win. Other cases cover a held strobe, strobes after the game ends, and a new-game request arriving in the same cycle as a roll. A design that counts levels instead of edges, lets the result escape its sticky state, or gives rolls priority over the clear would then produce an extra evaluation or a non-cleared state. A long random sequence is compared with a behavioural model on every cycle.

// File: rtl/dice_pkg.sv
package dice_pkg;

    localparam int DIE_W       = 3;
    localparam int SUM_W       = DIE_W + 1;
    localparam int SEVEN       = 7;
    localparam int ELEVEN      = 11;
    localparam int SNAKE_EYES  = 2;
    localparam int ACE_DEUCE   = 3;
    localparam int BOXCARS     = 12;

    typedef logic [DIE_W-1:0] die_t;
    typedef logic [SUM_W-1:0] sum_t;

    typedef enum logic [1:0] {
        GS_OPENING = 2'd0,
        GS_CHASING = 2'd1,
        GS_WON     = 2'd2,
        GS_LOST    = 2'd3
    } game_state_t;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_WIN   = 2'd1,
        VD_LOSE  = 2'd2,
        VD_POINT = 2'd3
    } verdict_t;

    typedef struct packed {
        logic fire;
        sum_t total;
    } roll_evt_t;

    function automatic logic opening_winner(input sum_t s);
        return (s == sum_t'(SEVEN)) || (s == sum_t'(ELEVEN));
    endfunction

    function automatic logic opening_loser(input sum_t s);
        return (s == sum_t'(SNAKE_EYES)) || (s == sum_t'(ACE_DEUCE)) ||
               (s == sum_t'(BOXCARS));
    endfunction

    function automatic sum_t add_dice(input die_t a, input die_t b);
        return sum_t'(a) + sum_t'(b);
    endfunction

endpackage

// File: rtl/dice_roll_capture.sv
module dice_roll_capture
    import dice_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      roll_i,
    input  die_t      die_a_i,
    input  die_t      die_b_i,
    output roll_evt_t evt_o
);
    logic roll_q;

    always_ff @(posedge clk) begin
        if (rst) roll_q <= 1'b0;
        else     roll_q <= roll_i;
    end

    always_comb begin
        evt_o.fire  = roll_i & ~roll_q;
        evt_o.total = add_dice(die_a_i, die_b_i);
    end

    // R7: an event never fires two cycles in a row
    assert_single_fire_R7: assert property (@(posedge clk) disable iff (rst)
        evt_o.fire |=> !evt_o.fire);
endmodule

// File: rtl/dice_verdict.sv
module dice_verdict
    import dice_pkg::*;
(
    input  game_state_t state_i,
    input  roll_evt_t   evt_i,
    input  sum_t        point_i,
    output verdict_t    verdict_o
);
    always_comb begin
        verdict_o = VD_NONE;
        if (evt_i.fire) begin
            unique case (state_i)
                GS_OPENING: begin
                    if (opening_winner(evt_i.total))      verdict_o = VD_WIN;
                    else if (opening_loser(evt_i.total))  verdict_o = VD_LOSE;
                    else                                  verdict_o = VD_POINT;
                end
                GS_CHASING: begin
                    if (evt_i.total == point_i)               verdict_o = VD_WIN;
                    else if (evt_i.total == sum_t'(SEVEN))    verdict_o = VD_LOSE;
                    else                                      verdict_o = VD_NONE;
                end
                default: verdict_o = VD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dice_point_store.sv
module dice_point_store
    import dice_pkg::*;
(
    input  logic clk,
    input  logic clr_i,
    input  logic load_i,
    input  sum_t d_i,
    output sum_t q_o
);
    always_ff @(posedge clk) begin
        if (clr_i)       q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/dice_referee.sv
module dice_referee
    import dice_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             new_game_i,
    input  logic             roll_i,
    input  logic [DIE_W-1:0] die_a_i,
    input  logic [DIE_W-1:0] die_b_i,
    output logic             win_o,
    output logic             lose_o,
    output logic             again_o,
    output logic [SUM_W-1:0] point_o
);
    game_state_t state_q, state_d;
    roll_evt_t   evt;
    verdict_t    verdict;
    sum_t        point_q;
    logic        clear;

    assign clear = rst | new_game_i;

    dice_roll_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .roll_i  (roll_i),
        .die_a_i (die_a_i),
        .die_b_i (die_b_i),
        .evt_o   (evt)
    );

    dice_verdict u_verdict (
        .state_i   (state_q),
        .evt_i     (evt),
        .point_i   (point_q),
        .verdict_o (verdict)
    );

    dice_point_store u_point (
        .clk    (clk),
        .clr_i  (clear),
        .load_i (verdict == VD_POINT),
        .d_i    (evt.total),
        .q_o    (point_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (verdict)
            VD_WIN:   state_d = GS_WON;
            VD_LOSE:  state_d = GS_LOST;
            VD_POINT: state_d = GS_CHASING;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clear) state_q <= GS_OPENING;
        else       state_q <= state_d;
    end

    assign win_o   = (state_q == GS_WON);
    assign lose_o  = (state_q == GS_LOST);
    assign again_o = (state_q == GS_CHASING);
    assign point_o = point_q;

    // R10: outcome flags are mutually exclusive
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({win_o, lose_o, again_o}));

    // R8: a finished game stays finished until cleared
    assert_sticky_win_R8: assert property (@(posedge clk) disable iff (rst)
        (win_o && !new_game_i) |=> win_o);
    assert_sticky_lose_R8: assert property (@(posedge clk) disable iff (rst)
        (lose_o && !new_game_i) |=> lose_o);

    // R6: the point does not move while chasing it
    assert_point_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (again_o && !new_game_i) |=> $stable(point_o));

    // R9: new game clears everything on the next cycle
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        new_game_i |=> (!win_o && !lose_o && !again_o && point_o == '0));

    // R3: a set point is always a legal point value
    assert_point_legal_R3: assert property (@(posedge clk) disable iff (rst)
        again_o |-> (point_o >= 4 && point_o <= 10 && point_o != sum_t'(SEVEN)));
endmodule

// File: tb/dice_referee_test.sv
module dice_referee_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       new_game_i = 1'b0;
    logic       roll_i = 1'b0;
    logic [2:0] die_a_i = 3'd1;
    logic [2:0] die_b_i = 3'd1;
    logic       win_o, lose_o, again_o;
    logic [3:0] point_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // behavioural model: 0 opening, 1 chasing, 2 won, 3 lost
    int m_phase = 0;
    int m_point = 0;
    bit m_prev  = 0;

    always #5 clk = ~clk;

    dice_referee uut (
        .clk(clk), .rst(rst), .new_game_i(new_game_i), .roll_i(roll_i),
        .die_a_i(die_a_i), .die_b_i(die_b_i),
        .win_o(win_o), .lose_o(lose_o), .again_o(again_o), .point_o(point_o)
    );

    task automatic model_edge();
        bit rising;
        int s;
        rising = roll_i && !m_prev;
        s = int'(die_a_i) + int'(die_b_i);
        if (rst) begin
            m_phase = 0; m_point = 0; m_prev = 0;
            return;
        end
        m_prev = roll_i;
        if (new_game_i) begin
            m_phase = 0; m_point = 0;
        end else if (rising) begin
            if (m_phase == 0) begin
                if (s == 7 || s == 11)                m_phase = 2;
                else if (s == 2 || s == 3 || s == 12) m_phase = 3;
                else begin m_phase = 1; m_point = s; end
            end else if (m_phase == 1) begin
                if (s == m_point) m_phase = 2;
                else if (s == 7)  m_phase = 3;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit ew, el, ea;
        ew = (m_phase == 2); el = (m_phase == 3); ea = (m_phase == 1);
        vectors++;
        if (win_o !== ew || lose_o !== el || again_o !== ea || point_o !== 4'(m_point)) begin
            misses++;
            $display("FAIL %s: actual win=%b lose=%b again=%b point=%0d expected win=%b lose=%b again=%b point=%0d",
                     tag, win_o, lose_o, again_o, point_o, ew, el, ea, m_point);
        end
    endtask

    // drive at negedge, clock it, check at next negedge
    task automatic step(input bit r, input bit ng, input bit rl,
                        input int a, input int b, input string tag);
        rst = r; new_game_i = ng; roll_i = rl;
        die_a_i = 3'(a); die_b_i = 3'(b);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic roll(input int a, input int b, input string tag);
        step(0, 0, 1, a, b, tag);
        step(0, 0, 0, a, b, tag);
    endtask

    task automatic fresh();
        step(0, 1, 0, 1, 1, "R9");
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 1, 1, "R9 reset");
        step(1, 0, 0, 1, 1, "R9 reset");
        step(0, 0, 0, 1, 1, "R9 idle");

        // every opening sum: R1, R2, R3
        for (int a = 1; a <= 6; a++) begin
            for (int b = 1; b <= 6; b++) begin
                fresh();
                roll(a, b, "R1 R2 R3 opening");
            end
        end

        // point then seven: R5, with non-deciding rolls: R6
        fresh(); roll(2, 2, "R3");
        roll(3, 3, "R6"); roll(5, 5, "R6");
        roll(3, 4, "R5");

        // point matched: R4
        fresh(); roll(4, 6, "R3");
        roll(2, 2, "R6"); roll(6, 2, "R6"); roll(1, 2, "R6"); roll(6, 6, "R6");
        roll(5, 5, "R4");

        // held strobe gives one evaluation: R7
        fresh();
        step(0, 0, 1, 3, 2, "R7");
        step(0, 0, 1, 2, 3, "R7 held");
        step(0, 0, 1, 4, 3, "R7 held");
        step(0, 0, 0, 1, 1, "R7");

        // rolls ignored after end: R8
        fresh(); roll(5, 6, "R1");
        roll(3, 4, "R8"); roll(1, 1, "R8"); roll(6, 6, "R8");
        fresh(); roll(1, 1, "R2");
        roll(5, 2, "R8"); roll(6, 5, "R8");

        // new game wins over a simultaneous roll: R9
        fresh(); roll(4, 4, "R3");
        step(0, 1, 1, 4, 4, "R9 clear beats roll");
        step(0, 0, 0, 1, 1, "R9");
        roll(6, 1, "R9 next is opening");

        // random play compared every cycle: R10 and all rules
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 29) == 0),
                 ($urandom_range(0, 2) == 0),
                 int'($urandom_range(1, 6)), int'($urandom_range(1, 6)), "R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual run still active, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule